// File: doc/BRIEF.md
# Dual-Channel PWM Timer

An 8-bit counter advanced by a programmable clock divider drives two compare channels, A and B. Each channel compares the counter against its own compare value. On a match it acts on its waveform pin: it can toggle, clear or set the pin, or do nothing. The counter runs in one of four waveform kinds: plain overflow counting, clear-on-compare (CTC), single-slope fast PWM and dual-slope phase-correct PWM. In some modes the period top comes from compare value A, and in the others it is the counter's full-scale value.

Configuration arrives as plain input fields: divider select, 3-bit waveform mode, one 2-bit pin-action field per channel, and two compare values. The block reports three single-cycle event flags: counter overflow and one match flag per channel. It also exposes the counter value. The pin action is decoded from the channel's pin-action field together with the current waveform mode. In the PWM modes the compare values are double-buffered, so a period never runs with a half-updated setting.

Top module: `pwm_timer8`

## Requirements
- R1: While reset is held low, count_o, wave_a_o, wave_b_o, ovf_o, match_a_o and match_b_o are all 0.
- R2: With clk_sel_i = 000 the counter never changes. With 001 it changes on every clock cycle.
- R3: With clk_sel_i values 010, 011, 100, 101, 110 and 111, the counter advances once every 8, 32, 64, 128, 256 and 1024 clock cycles respectively.
- R4: In wave_mode_i = 000 the counter runs 0 to 255 and wraps to 0. In the cycle that shows the wrapped value 0, ovf_o is 1, and it is 1 for that cycle only.
- R5: In wave_mode_i = 010 (CTC) the counter goes from compare value A to 0 on the next advance, and match_a_o pulses in the cycle that shows that 0.
- R6: In modes 000 and 010, a channel's pin-action field means: 01 toggle the pin on a match, 10 drive it 0 on a match, 11 drive it 1 on a match. Code 00 disconnects the pin, so its output reads 0 at once.
- R7: In fast PWM (011, top 255), pin-action 10 sets the pin when the counter wraps to 0 and clears it after a match, so the pin is high for compare+1 of every 256 advances. Pin-action 11 gives the complement.
- R8: In phase-correct PWM (001) the counter counts 0 up to 255, then down to 0, showing each end value once. ovf_o pulses in the cycle showing 1 after the turn at 0.
- R9: In phase-correct PWM, pin-action 10 clears the pin on a match while counting up and sets it on a match while counting down. Pin-action 11 is the inverse. With top 255 and compare 100, the high time is 200 of 510 advances for 10 and 310 for 11.
- R10: In modes 101 and 111 the period top is compare value A. A fast period is then compare A + 1 advances, and a phase-correct period never exceeds compare A. Channel A pin-action 01 toggles pin A on a match in 101 and 111, and leaves pin A at 0 in 001 and 011.
- R11: In every PWM mode (001, 011, 101, 111), channel B pin-action 01 keeps wave_b_o at 0.
- R12: In the PWM modes, a new compare value is applied only when fast PWM wraps to 0 or when phase-correct PWM turns at top. A change made in mid-period leaves that period's waveform unchanged.
- R13: The reserved codes 100 and 110 freeze the counter, raise no events and hold both waveform outputs at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_sel_i | input | 3 | Divider select: 000 stopped, 001 every cycle, 010..111 divide by 8, 32, 64, 128, 256, 1024 |
| wave_mode_i | input | 3 | Waveform mode code |
| out_mode_a_i | input | 2 | Pin-action field for channel A |
| out_mode_b_i | input | 2 | Pin-action field for channel B |
| cmp_a_i | input | 8 | Compare value A (also top in modes 010, 101, 111) |
| cmp_b_i | input | 8 | Compare value B |
| count_o | output | 8 | Current counter value |
| wave_a_o | output | 1 | Channel A waveform pin |
| wave_b_o | output | 1 | Channel B waveform pin |
| ovf_o | output | 1 | Overflow / bottom event, one cycle |
| match_a_o | output | 1 | Channel A compare match event, one cycle |
| match_b_o | output | 1 | Channel B compare match event, one cycle |

## Verification
The properties assume that the waveform mode and divider select are steady for at least one clock cycle around the advance they judge. A mode change can reposition the counter, and a property would otherwise attribute that jump to the wrong mode. The step and wrap checks also assume that compare A is not lowered below the running count while phase-correct mode is in use. The directed stimulus changes mode only under reset or once the counter is parked, and changes a compare value only at points the scenario defines. This keeps every scenario inside those assumptions.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    typedef enum logic [2:0] {
        WF_NORMAL,
        WF_CTC,
        WF_FAST,
        WF_PHASE,
        WF_HOLD
    } wf_kind_e;

    typedef enum logic [1:0] {
        PA_KEEP,
        PA_CLR,
        PA_SET,
        PA_TOG
    } pin_act_e;

    function automatic wf_kind_e wf_kind(input logic [2:0] mode);
        case (mode)
            3'b000:         return WF_NORMAL;
            3'b010:         return WF_CTC;
            3'b001, 3'b101: return WF_PHASE;
            3'b011, 3'b111: return WF_FAST;
            default:        return WF_HOLD;
        endcase
    endfunction

    function automatic logic top_from_a(input logic [2:0] mode);
        return (mode == 3'b010) || (mode == 3'b101) || (mode == 3'b111);
    endfunction

endpackage

// File: rtl/ptmr_prescale.sv
module ptmr_prescale #(
    parameter int DIV_W = 10
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [2:0] sel_i,
    output logic       tick_o
);
    logic [DIV_W-1:0] div_d, div_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        div_d = div_q + DIV_W'(1);
        case (sel_i)
            3'b010:  mask = DIV_W'(7);
            3'b011:  mask = DIV_W'(31);
            3'b100:  mask = DIV_W'(63);
            3'b101:  mask = DIV_W'(127);
            3'b110:  mask = DIV_W'(255);
            3'b111:  mask = DIV_W'(1023);
            default: mask = '0;
        endcase
        if (sel_i == 3'b000)      tick_o = 1'b0;
        else if (sel_i == 3'b001) tick_o = 1'b1;
        else                      tick_o = ((div_q & mask) == mask);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) div_q <= '0;
        else         div_q <= div_d;
    end
endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter
    import ptmr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic [2:0]       mode_i,
    input  logic [CNT_W-1:0] cmp_a_i,
    input  logic [CNT_W-1:0] cmp_b_i,
    output logic [CNT_W-1:0] count_o,
    output logic             down_o,
    output logic             ovf_evt_o,
    output logic             match_a_evt_o,
    output logic             match_b_evt_o
);
    localparam logic [CNT_W-1:0] MAXV = '1;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             down;
        logic [CNT_W-1:0] buf_a;
        logic [CNT_W-1:0] buf_b;
    } cstate_t;

    cstate_t  st_d, st_q;
    wf_kind_e kind;
    logic              pwm;
    logic [CNT_W-1:0]  act_a, act_b, top;
    logic              at_top;

    always_comb begin
        kind   = wf_kind(mode_i);
        pwm    = (kind == WF_FAST) || (kind == WF_PHASE);
        act_a  = pwm ? st_q.buf_a : cmp_a_i;
        act_b  = pwm ? st_q.buf_b : cmp_b_i;
        top    = top_from_a(mode_i) ? act_a : MAXV;
        at_top = (st_q.cnt == top);

        st_d      = st_q;
        ovf_evt_o = 1'b0;
        if (!pwm) begin
            st_d.buf_a = cmp_a_i;
            st_d.buf_b = cmp_b_i;
        end
        if (kind != WF_PHASE) st_d.down = 1'b0;

        if (tick_i) begin
            case (kind)
                WF_NORMAL: begin
                    st_d.cnt  = st_q.cnt + ONE;
                    ovf_evt_o = (st_q.cnt == MAXV);
                end
                WF_CTC: begin
                    st_d.cnt  = at_top ? '0 : st_q.cnt + ONE;
                    ovf_evt_o = (st_q.cnt == MAXV);
                end
                WF_FAST: begin
                    if (at_top) begin
                        st_d.cnt   = '0;
                        ovf_evt_o  = 1'b1;
                        st_d.buf_a = cmp_a_i;
                        st_d.buf_b = cmp_b_i;
                    end else begin
                        st_d.cnt = st_q.cnt + ONE;
                    end
                end
                WF_PHASE: begin
                    if (!st_q.down) begin
                        if (at_top) begin
                            st_d.buf_a = cmp_a_i;
                            st_d.buf_b = cmp_b_i;
                            if (top != '0) begin
                                st_d.down = 1'b1;
                                st_d.cnt  = st_q.cnt - ONE;
                            end
                        end else begin
                            st_d.cnt = st_q.cnt + ONE;
                        end
                    end else begin
                        if (st_q.cnt == '0) begin
                            st_d.down = 1'b0;
                            st_d.cnt  = ONE;
                            ovf_evt_o = 1'b1;
                        end else begin
                            st_d.cnt = st_q.cnt - ONE;
                        end
                    end
                end
                default: st_d.cnt = st_q.cnt;
            endcase
        end

        match_a_evt_o = tick_i && (kind != WF_HOLD) && (st_q.cnt == act_a);
        match_b_evt_o = tick_i && (kind != WF_HOLD) && (st_q.cnt == act_b);
        count_o       = st_q.cnt;
        down_o        = st_q.down;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/ptmr_pin.sv
module ptmr_pin
    import ptmr_pkg::*;
#(
    parameter bit IS_A = 1'b0
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [2:0] mode_i,
    input  logic [1:0] out_mode_i,
    input  logic       match_i,
    input  logic       down_i,
    input  logic       bottom_i,
    output logic       pin_o
);
    logic     pin_d, pin_q;
    logic     connected;
    pin_act_e act;
    wf_kind_e kind;

    always_comb begin
        kind      = wf_kind(mode_i);
        connected = (out_mode_i != 2'b00);
        act       = PA_KEEP;
        case (kind)
            WF_NORMAL, WF_CTC: begin
                if (match_i) begin
                    case (out_mode_i)
                        2'b01:   act = PA_TOG;
                        2'b10:   act = PA_CLR;
                        2'b11:   act = PA_SET;
                        default: act = PA_KEEP;
                    endcase
                end
            end
            WF_FAST, WF_PHASE: begin
                case (out_mode_i)
                    2'b01: begin
                        connected = IS_A && mode_i[2];
                        if (connected && match_i) act = PA_TOG;
                    end
                    2'b10: begin
                        if (kind == WF_FAST) begin
                            if (bottom_i)     act = PA_SET;
                            else if (match_i) act = PA_CLR;
                        end else if (match_i) begin
                            act = down_i ? PA_SET : PA_CLR;
                        end
                    end
                    2'b11: begin
                        if (kind == WF_FAST) begin
                            if (bottom_i)     act = PA_CLR;
                            else if (match_i) act = PA_SET;
                        end else if (match_i) begin
                            act = down_i ? PA_CLR : PA_SET;
                        end
                    end
                    default: act = PA_KEEP;
                endcase
            end
            default: connected = 1'b0;
        endcase

        case (act)
            PA_CLR:  pin_d = 1'b0;
            PA_SET:  pin_d = 1'b1;
            PA_TOG:  pin_d = ~pin_q;
            default: pin_d = pin_q;
        endcase
        pin_o = connected & pin_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pin_q <= 1'b0;
        else         pin_q <= pin_d;
    end
endmodule

// File: rtl/pwm_timer8.sv
module pwm_timer8 #(
    parameter int CNT_W = 8,
    parameter int DIV_W = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [2:0]       clk_sel_i,
    input  logic [2:0]       wave_mode_i,
    input  logic [1:0]       out_mode_a_i,
    input  logic [1:0]       out_mode_b_i,
    input  logic [CNT_W-1:0] cmp_a_i,
    input  logic [CNT_W-1:0] cmp_b_i,
    output logic [CNT_W-1:0] count_o,
    output logic             wave_a_o,
    output logic             wave_b_o,
    output logic             ovf_o,
    output logic             match_a_o,
    output logic             match_b_o
);
    localparam int NCH = 2;

    typedef struct packed {
        logic           ovf;
        logic [NCH-1:0] match;
    } flags_t;

    flags_t         flg_d, flg_q;
    logic           tick;
    logic           down;
    logic           ovf_evt;
    logic [NCH-1:0] match_evt;
    logic [NCH-1:0] pins;
    logic [1:0]     out_mode [NCH];

    assign out_mode[0] = out_mode_a_i;
    assign out_mode[1] = out_mode_b_i;

    ptmr_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sel_i  (clk_sel_i),
        .tick_o (tick)
    );

    ptmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .tick_i        (tick),
        .mode_i        (wave_mode_i),
        .cmp_a_i       (cmp_a_i),
        .cmp_b_i       (cmp_b_i),
        .count_o       (count_o),
        .down_o        (down),
        .ovf_evt_o     (ovf_evt),
        .match_a_evt_o (match_evt[0]),
        .match_b_evt_o (match_evt[1])
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        ptmr_pin #(.IS_A(g == 0)) u_pin (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .mode_i     (wave_mode_i),
            .out_mode_i (out_mode[g]),
            .match_i    (match_evt[g]),
            .down_i     (down),
            .bottom_i   (ovf_evt),
            .pin_o      (pins[g])
        );
    end

    always_comb begin
        flg_d.ovf   = ovf_evt;
        flg_d.match = match_evt;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) flg_q <= '0;
        else         flg_q <= flg_d;
    end

    assign wave_a_o  = pins[0];
    assign wave_b_o  = pins[1];
    assign ovf_o     = flg_q.ovf;
    assign match_a_o = flg_q.match[0];
    assign match_b_o = flg_q.match[1];
endmodule

// File: rtl/ptmr_checker.sv
module ptmr_checker (
    input logic       clk_i,
    input logic       rst_ni,
    input logic [2:0] clk_sel_i,
    input logic [2:0] wave_mode_i,
    input logic [1:0] out_mode_b_i,
    input logic [7:0] count_o,
    input logic       ovf_o,
    input logic       wave_b_o
);
    // R2: a stopped divider never moves the counter
    a_r2_stopped_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clk_sel_i == 3'b000) |=> $stable(count_o));

    // R13: reserved codes freeze the counter
    a_r13_reserved_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wave_mode_i[2] && !wave_mode_i[0]) |=> $stable(count_o));

    // R4: overflow flag in normal mode only shows the wrapped value
    a_r4_ovf_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovf_o && $past(wave_mode_i) == 3'b000) |-> (count_o == 8'd0));

    // R5: CTC steps by one or returns to zero
    a_r5_ctc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wave_mode_i == 3'b010 && $past(wave_mode_i) == 3'b010 && count_o != $past(count_o))
        |-> (count_o == 8'd0 || count_o == $past(count_o) + 8'd1));

    // R8: phase-correct with full-scale top moves one step at a time
    a_r8_phase_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wave_mode_i == 3'b001 && $past(wave_mode_i) == 3'b001 && count_o != $past(count_o))
        |-> (count_o == $past(count_o) + 8'd1 || count_o == $past(count_o) - 8'd1));

    // R11: channel B code 01 in PWM modes stays low
    a_r11_b_reserved_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wave_mode_i[0] && out_mode_b_i == 2'b01) |-> !wave_b_o);
endmodule

bind pwm_timer8 ptmr_checker u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clk_sel_i    (clk_sel_i),
    .wave_mode_i  (wave_mode_i),
    .out_mode_b_i (out_mode_b_i),
    .count_o      (count_o),
    .ovf_o        (ovf_o),
    .wave_b_o     (wave_b_o)
);

// File: tb/tb_pwm_timer8.sv
`timescale 1ns/1ps
module tb_pwm_timer8;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] clk_sel = 3'b000;
    logic [2:0] mode = 3'b000;
    logic [1:0] om_a = 2'b00;
    logic [1:0] om_b = 2'b00;
    logic [7:0] cmp_a = 8'd0;
    logic [7:0] cmp_b = 8'd0;
    logic [7:0] count;
    logic       wave_a, wave_b, ovf, m_a, m_b;

    int checks = 0;
    int errors = 0;
    bit timed_out = 1'b0;

    always #4 clk = ~clk;

    pwm_timer8 dut (
        .clk_i(clk), .rst_ni(rst_n), .clk_sel_i(clk_sel), .wave_mode_i(mode),
        .out_mode_a_i(om_a), .out_mode_b_i(om_b), .cmp_a_i(cmp_a), .cmp_b_i(cmp_b),
        .count_o(count), .wave_a_o(wave_a), .wave_b_o(wave_b), .ovf_o(ovf),
        .match_a_o(m_a), .match_b_o(m_b)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset_r1();
        clk_sel = 3'b001; mode = 3'b000;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(count == 0, "R1 count", count, 0);
        check({wave_a, wave_b, ovf, m_a, m_b} == 5'b0, "R1 outputs", {wave_a, wave_b, ovf, m_a, m_b}, 0);
    endtask

    task automatic t_stop_run_r2();
        int prev;
        bit ok;
        clk_sel = 3'b000; mode = 3'b000;
        do_reset();
        repeat (10) @(negedge clk);
        check(count == 0, "R2 stopped", count, 0);
        clk_sel = 3'b001;
        prev = count;
        ok = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (count != ((prev + 1) & 255)) ok = 1'b0;
            prev = count;
        end
        check(ok, "R2 every cycle", count, prev);
    endtask

    task automatic t_prescale_r3();
        int divs [6] = '{8, 32, 64, 128, 256, 1024};
        for (int s = 2; s <= 7; s++) begin
            int c0, c1, n;
            clk_sel = s[2:0];
            c0 = count;
            while (count == c0) @(negedge clk);
            c1 = count;
            n = 0;
            while (count == c1) begin @(negedge clk); n++; end
            check(n == divs[s-2], "R3 divider period", n, divs[s-2]);
        end
    endtask

    task automatic t_normal_r4();
        mode = 3'b000; clk_sel = 3'b001; om_a = 2'b00; om_b = 2'b00;
        do_reset();
        while (count != 8'd255) @(negedge clk);
        check(!ovf, "R4 no flag before wrap", ovf, 0);
        @(negedge clk);
        check(count == 0 && ovf, "R4 wrap with flag", {ovf, count}, 256);
        @(negedge clk);
        check(!ovf && count == 1, "R4 flag one cycle", {ovf, count}, 1);
        check(!wave_a && !wave_b, "R6 disconnected pins low", {wave_a, wave_b}, 0);
    endtask

    task automatic t_ctc_r5_r6();
        mode = 3'b010; clk_sel = 3'b001; cmp_a = 8'd9; cmp_b = 8'd4;
        om_a = 2'b01; om_b = 2'b11;
        do_reset();
        while (count != 8'd9) @(negedge clk);
        @(negedge clk);
        check(count == 0 && m_a, "R5 CTC return to zero with match", {m_a, count}, 256);
        check(wave_a == 1, "R6 toggle on match", wave_a, 1);
        check(wave_b == 1, "R6 set on match (B)", wave_b, 1);
        om_a = 2'b10;
        while (count != 8'd9) @(negedge clk);
        @(negedge clk);
        check(wave_a == 0, "R6 clear on match", wave_a, 0);
        om_a = 2'b11;
        while (count != 8'd9) @(negedge clk);
        @(negedge clk);
        check(wave_a == 1, "R6 set on match", wave_a, 1);
        om_a = 2'b00;
        #1;
        check(wave_a == 0, "R6 disconnect reads 0", wave_a, 0);
    endtask

    task automatic t_fast_r7_r12();
        int ha, hb;
        mode = 3'b011; clk_sel = 3'b001; cmp_a = 8'd63; cmp_b = 8'd63;
        om_a = 2'b10; om_b = 2'b11;
        do_reset();
        while (!ovf) @(negedge clk);
        ha = 0; hb = 0;
        for (int i = 0; i < 256; i++) begin
            ha += int'(wave_a); hb += int'(wave_b);
            @(negedge clk);
        end
        check(ha == 64, "R7 non-inverting duty", ha, 64);
        check(hb == 192, "R7 inverting duty", hb, 192);
        while (!ovf) @(negedge clk);
        ha = 0;
        for (int i = 0; i < 256; i++) begin
            ha += int'(wave_a);
            if (count == 8'd30) cmp_a = 8'd10;
            @(negedge clk);
        end
        check(ha == 64, "R12 mid-period change deferred", ha, 64);
        while (!ovf) @(negedge clk);
        ha = 0;
        for (int i = 0; i < 256; i++) begin
            ha += int'(wave_a);
            @(negedge clk);
        end
        check(ha == 11, "R12 new value after wrap", ha, 11);
    endtask

    task automatic t_phase_r8_r9();
        int ha, hb;
        mode = 3'b001; clk_sel = 3'b001; cmp_a = 8'd100; cmp_b = 8'd100;
        om_a = 2'b10; om_b = 2'b11;
        do_reset();
        while (count != 8'd255) @(negedge clk);
        @(negedge clk);
        check(count == 254, "R8 turn at top without repeat", count, 254);
        while (count != 8'd0) @(negedge clk);
        @(negedge clk);
        check(count == 1 && ovf, "R8 turn at bottom with flag", {ovf, count}, 257);
        ha = 0; hb = 0;
        for (int i = 0; i < 510; i++) begin
            ha += int'(wave_a); hb += int'(wave_b);
            @(negedge clk);
        end
        check(ha == 200, "R9 phase non-inverting duty", ha, 200);
        check(hb == 310, "R9 phase inverting duty", hb, 310);
        check(ovf && count == 1, "R8 period 510", {ovf, count}, 257);
    endtask

    task automatic t_top_a_r10_r11();
        int mx, tog, hb, n, prev_a;
        mode = 3'b101; clk_sel = 3'b001; cmp_a = 8'd20; cmp_b = 8'd5;
        om_a = 2'b01; om_b = 2'b01;
        do_reset();
        repeat (5) @(negedge clk);
        mx = 0; tog = 0; hb = 0;
        prev_a = wave_a;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (count > mx) mx = count;
            if (wave_a != prev_a) tog++;
            prev_a = wave_a;
            hb += int'(wave_b);
        end
        check(mx == 20, "R10 phase top from A", mx, 20);
        check(tog == 2, "R10 toggle A per period", tog, 2);
        check(hb == 0, "R11 B code 01 low", hb, 0);
        mode = 3'b001;
        #1;
        check(wave_a == 0, "R10 A code 01 off when bit2 clear", wave_a, 0);

        mode = 3'b111; cmp_a = 8'd49; om_a = 2'b00; om_b = 2'b00;
        do_reset();
        while (!ovf) @(negedge clk);
        @(negedge clk);
        while (!ovf) @(negedge clk);
        @(negedge clk);
        n = 1;
        while (!ovf) begin @(negedge clk); n++; end
        check(n == 50, "R10 fast period from A", n, 50);
    endtask

    task automatic t_reserved_r13();
        int c, bad;
        mode = 3'b000; clk_sel = 3'b001; cmp_a = 8'd3; om_a = 2'b11; om_b = 2'b00;
        do_reset();
        repeat (10) @(negedge clk);
        check(wave_a == 1, "R6 set in normal mode", wave_a, 1);
        mode = 3'b100;
        #1;
        c = count; bad = 0;
        check(wave_a == 0, "R13 pins low in reserved", wave_a, 0);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (count != c || ovf || m_a || m_b || wave_a || wave_b) bad++;
        end
        mode = 3'b110;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (count != c || ovf || wave_a) bad++;
        end
        check(bad == 0, "R13 frozen, no events", bad, 0);
    endtask

    initial begin
        fork
            begin
                t_reset_r1();
                t_stop_run_r2();
                t_prescale_r3();
                t_normal_r4();
                t_ctc_r5_r6();
                t_fast_r7_r12();
                t_phase_r8_r9();
                t_top_a_r10_r11();
                t_reserved_r13();
            end
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        if (timed_out) check(1'b0, "watchdog", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule